// File: doc/BRIEF.md
# TDM PCM Frame Serializer (Master Transmit)

This block is the transmit half of a time-division-multiplexed PCM audio link, run as the frame-sync master. It takes sample words through a valid/ready handshake, one word per channel slot. It shifts each word out on a serial data line and drives a frame-sync line that marks slot 0. Bit timing comes from a single-cycle bit-clock enable, so the block runs in the system clock domain. Everything advances only on cycles where that enable is high.

The configuration inputs select:
- the slot count per frame;
- the slot width in bit clocks;
- the sample data width;
- a short or long frame-sync pulse.

The block samples these inputs only when a new frame starts, so one frame always uses a single setting. When the slot width is smaller than the sample width, the slot is stretched to the sample width. If no word is waiting when a slot begins, the slot carries zeros and a one-clock underflow pulse is raised.

Top module: `tdm_pcm_tx`

## Requirements
- R1: `slot_cnt_sel` codes 0, 1, 2 and 3 give 2, 4, 6 and 8 slots per frame. The frame length in bit clocks is the slot count times the effective slot length.
- R2: `slot_w_sel` codes 0, 1, 2 and 3 give a nominal slot of 8, 16, 24 and 32 bit clocks.
- R3: `data_w_sel` uses the same encoding as `slot_w_sel` (codes 0 to 3 give 8, 16, 24 and 32 bits). The effective slot length is the larger of the slot width and the data width.
- R4: With `sync_slot_long` = 0, `fsync` is high for exactly the first bit clock of slot 0 and low otherwise.
- R5: With `sync_slot_long` = 1, `fsync` is high for every bit clock of slot 0 and low in all other slots.
- R6: A slot carries bits [DW-1:0] of its word, MSB first, starting on the slot's first bit clock, where DW is the data width. Word bits above DW are ignored. Slot bits after the first DW are 0.
- R7: The configuration inputs are sampled only at the first bit clock of a frame. A change made mid-frame first affects the next frame.
- R8: If no word is held when a slot's first bit clock occurs, the slot is all zeros and `underflow` is high for exactly one clock.
- R9: `s_ready` is high when the one-word holding register is empty. A word is taken on a clock with `s_valid` and `s_ready` both high. The held word is consumed on the first bit clock of a slot.
- R10: While `enable` is low, `fsync`, `sdata` and `underflow` are 0 after the next clock, and the position counters restart. The first bit clock after `enable` returns is slot 0, bit 0.
- R11: `fsync` and `sdata` change only on clocks where `bclk_en` and `enable` are high, and hold their values otherwise.
- R12: After reset, `fsync`, `sdata` and `underflow` are 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global run enable; low clears outputs and counters |
| bclk_en | input | 1 | One-clock pulse marking each bit-clock period |
| slot_cnt_sel | input | 2 | Slots per frame: 2, 4, 6, 8 |
| slot_w_sel | input | 2 | Nominal slot width: 8, 16, 24, 32 bit clocks |
| data_w_sel | input | 2 | Sample width: 8, 16, 24, 32 bits |
| sync_slot_long | input | 1 | 0: one-bit sync pulse, 1: whole-slot sync pulse |
| s_data | input | SAMPLE_W | Sample word, right-justified |
| s_valid | input | 1 | Sample word present |
| s_ready | output | 1 | Holding register empty |
| fsync | output | 1 | Frame-sync output |
| sdata | output | 1 | Serial data output |
| underflow | output | 1 | One-clock pulse when a slot starts with no word |

## Verification
`fsync`, `sdata` and `underflow` are registered on the clock edge where `bclk_en` is high. The bench raises `bclk_en` on a falling edge and compares the bit for that position on the next falling edge, one full clock later. It expects `underflow` low again on the clock after that. `s_ready` is expected to fall one clock after an accepted word and to rise one clock after the slot start that consumes it. Outputs are expected to be zero one clock after `enable` drops. Frame lengths are counted in bit clocks between rising edges of `fsync` and compared with the slot count times the larger of the two widths. The length check is swept over every combination of the configuration fields.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

   localparam int LEN_W = 6;

   typedef struct packed {
      logic [1:0] slots_sel;
      logic [1:0] slot_w_sel;
      logic [1:0] data_w_sel;
      logic       sync_long;
   } tdm_cfg_t;

   function automatic logic [LEN_W-1:0] sel_to_len(input logic [1:0] sel);
      return LEN_W'((32'(sel) + 32'd1) * 32'd8);
   endfunction

   function automatic logic [3:0] sel_to_slots(input logic [1:0] sel);
      return 4'((32'(sel) + 32'd1) * 32'd2);
   endfunction

endpackage

// File: rtl/tdm_cfg_latch.sv
module tdm_cfg_latch
   import tdm_pkg::*;
#(
   parameter int SLOT_NW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               use_new,
   input  tdm_cfg_t           cfg_in,
   output logic [LEN_W-1:0]   slot_len,
   output logic [LEN_W-1:0]   data_len,
   output logic [SLOT_NW-1:0] n_slots,
   output logic               sync_long
);

   tdm_cfg_t         act_q;
   tdm_cfg_t         cur;
   logic [LEN_W-1:0] nom_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (load) begin
         act_q <= cfg_in;
      end
   end

   always_comb begin
      cur       = use_new ? cfg_in : act_q;
      nom_len   = sel_to_len(cur.slot_w_sel);
      data_len  = sel_to_len(cur.data_w_sel);
      slot_len  = (nom_len > data_len) ? nom_len : data_len;
      n_slots   = SLOT_NW'(sel_to_slots(cur.slots_sel));
      sync_long = cur.sync_long;
   end

endmodule

// File: rtl/tdm_slot_pos.sv
module tdm_slot_pos
   import tdm_pkg::*;
#(
   parameter int SLOT_CW = 3,
   parameter int SLOT_NW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               step,
   input  logic [LEN_W-1:0]   slot_len,
   input  logic [SLOT_NW-1:0] n_slots,
   output logic [LEN_W-1:0]   bit_cnt,
   output logic [SLOT_CW-1:0] slot_cnt,
   output logic               frame_start,
   output logic               slot_start
);

   logic [LEN_W-1:0]   bit_nxt;
   logic [SLOT_NW-1:0] slot_nxt;

   assign bit_nxt     = bit_cnt + LEN_W'(1);
   assign slot_nxt    = SLOT_NW'(slot_cnt) + SLOT_NW'(1);
   assign slot_start  = (bit_cnt == '0);
   assign frame_start = slot_start && (slot_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         bit_cnt  <= '0;
         slot_cnt <= '0;
      end else if (step) begin
         if (bit_nxt == slot_len) begin
            bit_cnt <= '0;
            if (slot_nxt == n_slots) begin
               slot_cnt <= '0;
            end else begin
               slot_cnt <= slot_cnt + SLOT_CW'(1);
            end
         end else begin
            bit_cnt <= bit_nxt;
         end
      end
   end

endmodule

// File: rtl/tdm_word_hold.sv
module tdm_word_hold #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s_data,
   input  logic         s_valid,
   input  logic         take,
   output logic         s_ready,
   output logic [W-1:0] word,
   output logic         full
);

   assign s_ready = !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         word <= '0;
      end else begin
         if (take) begin
            full <= 1'b0;
         end
         if (s_valid && s_ready) begin
            full <= 1'b1;
            word <= s_data;
         end
      end
   end

endmodule

// File: rtl/tdm_bit_shift.sv
module tdm_bit_shift
   import tdm_pkg::*;
#(
   parameter int W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             step,
   input  logic             slot_start,
   input  logic             have_word,
   input  logic [W-1:0]     word,
   input  logic [LEN_W-1:0] data_len,
   input  logic             fs_now,
   output logic             fsync,
   output logic             sdata,
   output logic             underflow
);

   localparam int SH_W = $clog2(W + 1);

   logic [W-1:0]    sh_q;
   logic [W-1:0]    aligned;
   logic [SH_W-1:0] shamt;

   always_comb begin
      shamt   = SH_W'(W) - SH_W'(data_len);
      aligned = have_word ? (word << shamt) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         sh_q      <= '0;
         sdata     <= 1'b0;
         fsync     <= 1'b0;
         underflow <= 1'b0;
      end else begin
         underflow <= step && slot_start && !have_word;
         if (step) begin
            fsync <= fs_now;
            if (slot_start) begin
               sdata <= aligned[W-1];
               sh_q  <= aligned << 1;
            end else begin
               sdata <= sh_q[W-1];
               sh_q  <= sh_q << 1;
            end
         end
      end
   end

endmodule

// File: rtl/tdm_pcm_tx.sv
module tdm_pcm_tx
   import tdm_pkg::*;
#(
   parameter int SAMPLE_W  = 32,
   parameter int MAX_SLOTS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                bclk_en,
   input  logic [1:0]          slot_cnt_sel,
   input  logic [1:0]          slot_w_sel,
   input  logic [1:0]          data_w_sel,
   input  logic                sync_slot_long,
   input  logic [SAMPLE_W-1:0] s_data,
   input  logic                s_valid,
   output logic                s_ready,
   output logic                fsync,
   output logic                sdata,
   output logic                underflow
);

   localparam int SLOT_CW = $clog2(MAX_SLOTS);
   localparam int SLOT_NW = $clog2(MAX_SLOTS + 1);

   if (SAMPLE_W < 32) begin : g_bad_sample_w
      $error("tdm_pcm_tx: SAMPLE_W must hold a 32-bit sample");
   end
   if (MAX_SLOTS < 8) begin : g_bad_slots
      $error("tdm_pcm_tx: MAX_SLOTS must cover 8 slots");
   end

   tdm_cfg_t           cfg_in;
   logic               step;
   logic [LEN_W-1:0]   slot_len;
   logic [LEN_W-1:0]   data_len;
   logic [SLOT_NW-1:0] n_slots;
   logic               sync_long;
   logic [LEN_W-1:0]   bit_cnt;
   logic [SLOT_CW-1:0] slot_cnt;
   logic               frame_start;
   logic               slot_start;
   logic [SAMPLE_W-1:0] held_word;
   logic               held_full;
   logic               take;
   logic               fs_now;

   assign cfg_in = '{slots_sel:  slot_cnt_sel,
                     slot_w_sel: slot_w_sel,
                     data_w_sel: data_w_sel,
                     sync_long:  sync_slot_long};
   assign step   = enable && bclk_en;
   assign take   = step && slot_start && held_full;
   assign fs_now = sync_long ? (slot_cnt == '0) : frame_start;

   tdm_cfg_latch #(.SLOT_NW(SLOT_NW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (step && frame_start),
      .use_new  (frame_start),
      .cfg_in   (cfg_in),
      .slot_len (slot_len),
      .data_len (data_len),
      .n_slots  (n_slots),
      .sync_long(sync_long)
   );

   tdm_slot_pos #(.SLOT_CW(SLOT_CW), .SLOT_NW(SLOT_NW)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .step       (step),
      .slot_len   (slot_len),
      .n_slots    (n_slots),
      .bit_cnt    (bit_cnt),
      .slot_cnt   (slot_cnt),
      .frame_start(frame_start),
      .slot_start (slot_start)
   );

   tdm_word_hold #(.W(SAMPLE_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .s_data (s_data),
      .s_valid(s_valid),
      .take   (take),
      .s_ready(s_ready),
      .word   (held_word),
      .full   (held_full)
   );

   tdm_bit_shift #(.W(SAMPLE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .step      (step),
      .slot_start(slot_start),
      .have_word (held_full),
      .word      (held_word),
      .data_len  (data_len),
      .fs_now    (fs_now),
      .fsync     (fsync),
      .sdata     (sdata),
      .underflow (underflow)
   );

endmodule

// File: rtl/tdm_pcm_tx_chk.sv
module tdm_pcm_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic bclk_en,
   input logic s_valid,
   input logic s_ready,
   input logic fsync,
   input logic sdata,
   input logic underflow
);

   // R8: underflow is a single-clock pulse
   p_uf_one_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> !underflow);

   // R8: underflow only follows a bit-clock edge
   p_uf_on_bclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> $past(bclk_en && enable));

   // R9: holding register closes after an accepted word
   p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> !s_ready);

   // R10: outputs quiet while disabled
   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!fsync && !sdata && !underflow));

   // R11: no movement without a bit-clock enable
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !bclk_en) |=> ($stable(fsync) && $stable(sdata)));

endmodule

bind tdm_pcm_tx tdm_pcm_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .bclk_en  (bclk_en),
   .s_valid  (s_valid),
   .s_ready  (s_ready),
   .fsync    (fsync),
   .sdata    (sdata),
   .underflow(underflow)
);

// File: tb/tb_tdm_pcm_tx.sv
module tb_tdm_pcm_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        bclk_en = 1'b0;
   logic [1:0]  slot_cnt_sel = 2'd0;
   logic [1:0]  slot_w_sel = 2'd0;
   logic [1:0]  data_w_sel = 2'd0;
   logic        sync_slot_long = 1'b0;
   logic [31:0] s_data = '0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic        fsync;
   logic        sdata;
   logic        underflow;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model state
   int          m_slot = 0, m_bit = 0;
   int          a_ns = 2, a_eff = 8, a_dw = 8;
   bit          a_long = 0;
   bit          m_full = 0;
   logic [31:0] m_buf = '0, cur = '0;
   bit          cur_uf = 0;
   bit          e_fs = 0, e_sd = 0;
   int          nxt = 0;
   int          uf_seen = 0;

   always #4 clk = ~clk;

   tdm_pcm_tx dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bclk_en(bclk_en),
      .slot_cnt_sel(slot_cnt_sel), .slot_w_sel(slot_w_sel),
      .data_w_sel(data_w_sel), .sync_slot_long(sync_slot_long),
      .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
      .fsync(fsync), .sdata(sdata), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] gen(input int n);
      return (32'(n) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic int wlen(input logic [1:0] sel);
      return (int'(sel) + 1) * 8;
   endfunction

   function automatic int frame_len(input logic [1:0] sc, input logic [1:0] sw,
                                    input logic [1:0] dw);
      int e;
      e = (wlen(sw) > wlen(dw)) ? wlen(sw) : wlen(dw);
      return (int'(sc) + 1) * 2 * e;
   endfunction

   task automatic step(input bit bc, input bit feed);
      bit          hs;
      logic [31:0] w;
      bit          e_uf;
      string       ft, dt;
      bclk_en = bc;
      if (feed && s_ready) begin
         s_valid = 1'b1;
         s_data  = gen(nxt);
         hs      = 1;
      end else begin
         s_valid = 1'b0;
         hs      = 0;
      end
      w = s_data;
      @(posedge clk);
      @(negedge clk);
      e_uf = 0;
      if (!enable) begin
         m_slot = 0; m_bit = 0; e_fs = 0; e_sd = 0;
         ft = "R10"; dt = "R10";
      end else if (!bc) begin
         ft = "R11"; dt = "R11";
      end else begin
         if (m_slot == 0 && m_bit == 0) begin
            a_ns   = (int'(slot_cnt_sel) + 1) * 2;
            a_dw   = wlen(data_w_sel);
            a_eff  = (wlen(slot_w_sel) > a_dw) ? wlen(slot_w_sel) : a_dw;
            a_long = sync_slot_long;
         end
         if (m_bit == 0) begin
            if (m_full) begin
               cur = m_buf; m_full = 0; cur_uf = 0;
            end else begin
               cur = '0; e_uf = 1; cur_uf = 1;
            end
         end
         e_fs = a_long ? (m_slot == 0) : (m_slot == 0 && m_bit == 0);
         e_sd = (m_bit < a_dw) ? cur[a_dw-1-m_bit] : 1'b0;
         ft = a_long ? "R5" : "R4";
         dt = cur_uf ? "R8" : "R6";
         m_bit++;
         if (m_bit == a_eff) begin
            m_bit = 0;
            m_slot++;
            if (m_slot == a_ns) m_slot = 0;
         end
      end
      chk(fsync == e_fs, ft, "fsync", int'(fsync), int'(e_fs));
      chk(sdata == e_sd, dt, "sdata", int'(sdata), int'(e_sd));
      chk(underflow == e_uf, "R8", "underflow", int'(underflow), int'(e_uf));
      if (underflow) uf_seen++;
      if (hs) begin
         m_full = 1; m_buf = w; nxt++;
      end
      s_valid = 1'b0;
   endtask

   task automatic align();
      for (int g = 0; g < 600; g++) begin
         if (m_slot == 0 && m_bit == 0) break;
         step(1, 1);
      end
   endtask

   task automatic measure(input bit gap, output int len);
      bit pf;
      if (gap) step(0, 1);
      step(1, 1);
      len = 1;
      for (int g = 0; g < 600; g++) begin
         pf = fsync;
         if (gap) step(0, 1);
         step(1, 1);
         if (!pf && fsync) break;
         len++;
      end
   endtask

   task automatic set_cfg(input logic [1:0] sc, input logic [1:0] sw,
                          input logic [1:0] dw, input bit sl);
      slot_cnt_sel = sc; slot_w_sel = sw; data_w_sel = dw; sync_slot_long = sl;
   endtask

   initial begin
      int len;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R12: reset state
      chk(fsync == 0, "R12", "fsync", int'(fsync), 0);
      chk(sdata == 0, "R12", "sdata", int'(sdata), 0);
      chk(underflow == 0, "R12", "underflow", int'(underflow), 0);
      chk(s_ready == 1, "R12", "s_ready", int'(s_ready), 1);

      // R9: handshake and consumption
      set_cfg(2'd0, 2'd0, 2'd0, 1'b0);
      step(0, 1);
      chk(s_ready == 0, "R9", "s_ready after accept", int'(s_ready), 0);
      step(0, 1);
      chk(s_ready == 0, "R9", "s_ready while held", int'(s_ready), 0);
      enable = 1'b1;
      step(1, 0);
      chk(s_ready == 1, "R9", "s_ready after slot start", int'(s_ready), 1);
      chk(fsync == 1, "R9", "fsync at first bit", int'(fsync), 1);

      // R1 R2 R3 R4 R5 R6: full sweep of the configuration fields
      for (int sc = 0; sc < 4; sc++)
         for (int sw = 0; sw < 4; sw++)
            for (int dw = 0; dw < 4; dw++)
               for (int sl = 0; sl < 2; sl++) begin
                  set_cfg(2'(sc), 2'(sw), 2'(dw), sl[0]);
                  align();
                  measure(0, len);
                  chk(len == frame_len(2'(sc), 2'(sw), 2'(dw)), "R1/R2/R3",
                      "frame length", len, frame_len(2'(sc), 2'(sw), 2'(dw)));
               end

      // R7: mid-frame change waits for the boundary
      set_cfg(2'd0, 2'd0, 2'd0, 1'b0);
      align();
      step(1, 1);
      len = 1;
      for (int i = 0; i < 4; i++) begin step(1, 1); len++; end
      set_cfg(2'd1, 2'd1, 2'd0, 1'b1);
      for (int g = 0; g < 600; g++) begin
         bit pf;
         pf = fsync;
         step(1, 1);
         if (!pf && fsync) break;
         len++;
      end
      chk(len == 16, "R7", "frame length after mid-frame change", len, 16);
      align();
      measure(0, len);
      chk(len == 64, "R7", "next frame uses new setting", len, 64);

      // R11: gaps between bit clocks
      set_cfg(2'd1, 2'd1, 2'd2, 1'b1);
      align();
      measure(1, len);
      chk(len == 96, "R11", "frame length with gapped bit clock", len, 96);

      // R8: starved slots
      set_cfg(2'd0, 2'd0, 2'd0, 1'b0);
      align();
      uf_seen = 0;
      for (int i = 0; i < 32; i++) begin
         step(1, 0);
         step(0, 0);
      end
      chk(uf_seen == 3, "R8", "underflow pulses in starved run", uf_seen, 3);
      align();
      measure(0, len);
      chk(len == 16, "R8", "frame length after recovery", len, 16);

      // R10: enable drop mid-frame and restart
      set_cfg(2'd1, 2'd3, 2'd3, 1'b1);
      align();
      for (int i = 0; i < 40; i++) step(1, 1);
      enable = 1'b0;
      for (int i = 0; i < 3; i++) step(1, 1);
      chk(fsync == 0 && sdata == 0, "R10", "outputs while disabled",
          int'({fsync, sdata}), 0);
      enable = 1'b1;
      step(1, 1);
      chk(fsync == 1, "R10", "restart at slot 0", int'(fsync), 1);
      align();
      measure(0, len);
      chk(len == 128, "R10", "frame length after restart", len, 128);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule